// File: doc/BRIEF.md
# Mixture-Component Cell Allocation Scheduler

This block plans how a column of memory cells is programmed once, with no verify step, so that the conductances left in the column follow a mixture of weighted normal components. Each component is held as three values: a mixing weight, a median conductance code, and the programming-current code that produces that median. The spread of a component is not configurable, because it follows from the median.

In column mode the block turns the weights into whole cell counts. Each count is the weight times the column size, rounded to the nearest integer. The last component takes whatever remains, so the counts always add up to the column size. The block then issues one program command per cell. Commands go out in ascending address order, and the components are grouped in index order.

In row mode the block takes a stream of sampled parameter values. It snaps each value to the nearest stored median and issues one command per value, at consecutive addresses. The stream is ordered row by row, so all parameters of one sampled model land in the same row. The commands leave on a valid/ready handshake, and a one-cycle done pulse follows the last cell.

Top module: `mix_alloc_sched`

## Requirements
- R1: Weights are unsigned Q0.16 fractions. For every component except the last, the count is floor((N_CELLS*w + 32768) / 65536). Each count is limited to the cells not yet given to lower-indexed components.
- R2: The last component receives N_CELLS minus the sum of all other counts. The counts therefore always total exactly N_CELLS.
- R3: Column mode issues exactly N_CELLS commands at addresses 0, 1, ..., N_CELLS-1. Commands come grouped by component in ascending index, one command per cell of that component's count. Each command carries the component index and that component's current code. Components with a zero count emit nothing.
- R4: In row mode, each accepted sample produces exactly one command. Its component is the one whose median has the smallest absolute distance to the sample, and a tie goes to the lower index. The command carries that component's current code.
- R5: In row mode, command addresses start at 0 and rise by one per sample in arrival order.
- R6: A write to a median (cfg_field=1) with a value outside 40..240 is rejected. The stored median stays unchanged, and cfg_reject is high for the one cycle after the write. Writes inside the range are accepted, the bounds 40 and 240 included. cfg_field=0 writes a weight and cfg_field=2 writes a current code.
- R7: While cmd_valid is high and cmd_ready is low, cmd_valid stays high in the next cycle, and cmd_addr, cmd_code and cmd_comp keep their values.
- R8: done is high for exactly one cycle, in the cycle after the handshake of command N_CELLS. No command is valid in that cycle.
- R9: In reset, cmd_valid, done, smp_ready and cfg_reject are low.
- R10: A start request that arrives while a run is in progress is ignored, and the current run completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | 0 weight, 1 median, 2 current code |
| cfg_idx | input | IDX_W | Component index written |
| cfg_wdata | input | W_BITS | Write data |
| cfg_reject | output | 1 | Median write refused (one cycle) |
| start_col | input | 1 | Begin a column allocation run |
| start_row | input | 1 | Begin a row-wise quantized run |
| smp_valid | input | 1 | Sample value present |
| smp_ready | output | 1 | Block accepts a sample |
| smp_value | input | CODE_BITS | Sampled conductance code |
| cmd_valid | output | 1 | Program command present |
| cmd_ready | input | 1 | Command taken by the driver |
| cmd_addr | output | ADDR_W | Cell address of the command |
| cmd_code | output | CODE_BITS | Programming-current code |
| cmd_comp | output | IDX_W | Component index of the command |
| done | output | 1 | Pulse after the last cell |

## Verification
Column runs use five weight sets: the 85/333/107/177/322 reference split, random weights whose rounded sum exceeds the column (which exercises saturation), a single full-scale weight, all-zero weights (everything falls to the last component), and two half weights that starve the later components. Row runs mix random samples with directed values: exact medians, the extremes 0 and 255, and midpoints between two medians, which separate the lower-index tie rule from the alternatives. Out-of-range, wide and boundary median writes show whether a rejected value later changes the quantization. A start request injected mid-run, together with a randomly throttled ready, shows whether the sequence or the held payload is disturbed.

// File: rtl/mix_alloc_pkg.sv
// Shared encodings for the mixture allocation scheduler.
// Assumes: cfg_field is two bits wide; value 3 is unused.
package mix_alloc_pkg;

    typedef enum logic [1:0] {
        FLD_WEIGHT = 2'd0,
        FLD_MEDIAN = 2'd1,
        FLD_CODE   = 2'd2,
        FLD_NONE   = 2'd3
    } cfg_fld_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CALC,
        SQ_COL_LOAD,
        SQ_COL_ISSUE,
        SQ_ROW_WAIT,
        SQ_ROW_SEARCH,
        SQ_ROW_ISSUE
    } seq_state_e;

endpackage

// File: rtl/mix_cfg_regs.sv
// Per-component configuration store: weight, median code, current code.
// Refuses median values outside MED_LO..MED_HI and flags the refusal
// one cycle later. Assumes W_BITS >= CODE_BITS.
module mix_cfg_regs
    import mix_alloc_pkg::*;
#(
    parameter int K_COMP    = 5,
    parameter int W_BITS    = 16,
    parameter int CODE_BITS = 8,
    parameter int MED_LO    = 40,
    parameter int MED_HI    = 240,
    parameter int IDX_W     = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [1:0]                       cfg_field,
    input  logic [IDX_W-1:0]                 cfg_idx,
    input  logic [W_BITS-1:0]                cfg_wdata,
    output logic                             cfg_reject,
    output logic [K_COMP-1:0][W_BITS-1:0]    weights,
    output logic [K_COMP-1:0][CODE_BITS-1:0] medians,
    output logic [K_COMP-1:0][CODE_BITS-1:0] codes
);

    logic med_ok;

    // Range test on the full write word, so wide values also fail
    assign med_ok = (cfg_wdata >= W_BITS'(MED_LO)) && (cfg_wdata <= W_BITS'(MED_HI));

    // Refusal flag, one cycle after a bad median write
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_reject <= 1'b0;
        else        cfg_reject <= cfg_we && (cfg_field == FLD_MEDIAN) && !med_ok;
    end

    for (genvar g = 0; g < K_COMP; g++) begin : g_ent
        logic sel;
        assign sel = cfg_we && (cfg_idx == IDX_W'(g));

        // Field update for component g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                weights[g] <= '0;
                medians[g] <= CODE_BITS'(MED_LO);
                codes[g]   <= '0;
            end else if (sel) begin
                case (cfg_field)
                    FLD_WEIGHT: weights[g] <= cfg_wdata;
                    FLD_MEDIAN: if (med_ok) medians[g] <= cfg_wdata[CODE_BITS-1:0];
                    FLD_CODE:   codes[g]   <= cfg_wdata[CODE_BITS-1:0];
                    default: ;
                endcase
            end
        end

        // R6
        med_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && (cfg_field == FLD_MEDIAN) && !med_ok) |=> $stable(medians[g]));
    end

endmodule

// File: rtl/mix_count_calc.sv
// Turns Q0.16 weights into rounded cell counts, one component per cycle.
// Each count is limited to the cells still free; the last takes the rest.
// Assumes weights are stable from start until done.
module mix_count_calc #(
    parameter int N_CELLS = 1024,
    parameter int K_COMP  = 5,
    parameter int W_BITS  = 16,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [K_COMP-1:0][W_BITS-1:0] weights,
    output logic [K_COMP-1:0][CNT_W-1:0]  counts,
    output logic                          done
);

    localparam int PW = CNT_W + W_BITS + 1;

    logic             busy_q;
    logic [IDX_W-1:0] k_q;
    logic [CNT_W-1:0] acc_q;
    logic [PW-1:0]    prod;
    logic [PW-1:0]    rnd;
    logic [CNT_W-1:0] room;
    logic [CNT_W-1:0] pick;
    logic             is_last;

    // Rounded share of the current component, limited to the free cells
    always_comb begin
        prod    = PW'(N_CELLS) * PW'(weights[k_q]) + PW'(1 << (W_BITS - 1));
        rnd     = prod >> W_BITS;
        room    = CNT_W'(N_CELLS) - acc_q;
        is_last = (k_q == IDX_W'(K_COMP - 1));
        if (is_last || (rnd > PW'(room))) pick = room;
        else                               pick = rnd[CNT_W-1:0];
    end

    // One component per cycle until the last one is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            k_q    <= '0;
            acc_q  <= '0;
            done   <= 1'b0;
            counts <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                k_q    <= '0;
                acc_q  <= '0;
            end else if (busy_q) begin
                counts[k_q] <= pick;
                acc_q       <= acc_q + pick;
                if (is_last) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    k_q <= k_q + 1'b1;
                end
            end
        end
    end

    // R2
    total_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_q == CNT_W'(N_CELLS)));

    // R1
    share_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (acc_q <= CNT_W'(N_CELLS)));

endmodule

// File: rtl/mix_nearest_search.sv
// Sequential nearest-median search: one comparison per cycle over all
// components. Only a strictly smaller distance replaces the best, so a tie
// keeps the lower index. Result valid with the done pulse.
module mix_nearest_search #(
    parameter int K_COMP    = 5,
    parameter int CODE_BITS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [CODE_BITS-1:0]             value,
    input  logic [K_COMP-1:0][CODE_BITS-1:0] medians,
    output logic                             done,
    output logic [IDX_W-1:0]                 idx
);

    localparam int DW = CODE_BITS + 1;

    logic                 busy_q;
    logic [IDX_W-1:0]     k_q;
    logic [CODE_BITS-1:0] val_q;
    logic [DW-1:0]        best_d;
    logic [CODE_BITS-1:0] med;
    logic [CODE_BITS-1:0] diff;

    // Absolute distance to the median under test
    always_comb begin
        med  = medians[k_q];
        diff = (val_q >= med) ? (val_q - med) : (med - val_q);
    end

    // Walk the components, keeping the first minimum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            k_q    <= '0;
            val_q  <= '0;
            best_d <= '1;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                k_q    <= '0;
                val_q  <= value;
                best_d <= '1;
                idx    <= '0;
            end else if (busy_q) begin
                if ({1'b0, diff} < best_d) begin
                    best_d <= {1'b0, diff};
                    idx    <= k_q;
                end
                if (k_q == IDX_W'(K_COMP - 1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    k_q <= k_q + 1'b1;
                end
            end
        end
    end

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, idx} < (IDX_W + 1)'(K_COMP)));

    // R4
    search_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> busy_q);

endmodule

// File: rtl/mix_issue_seq.sv
// Command sequencer for both modes. Column mode walks the components in
// index order and spends each count; row mode sends one sample at a time
// through the nearest search. One command per cell, addresses ascending.
// Assumes configuration is not written while a run is in progress.
module mix_issue_seq
    import mix_alloc_pkg::*;
#(
    parameter int N_CELLS   = 1024,
    parameter int K_COMP    = 5,
    parameter int CODE_BITS = 8,
    parameter int IDX_W     = 3,
    parameter int ADDR_W    = 10,
    parameter int CNT_W     = 11
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_col,
    input  logic                             start_row,
    output logic                             calc_start,
    input  logic                             calc_done,
    input  logic [K_COMP-1:0][CNT_W-1:0]     counts,
    input  logic                             smp_valid,
    output logic                             smp_ready,
    output logic                             q_start,
    input  logic                             q_done,
    input  logic [IDX_W-1:0]                 q_idx,
    input  logic [K_COMP-1:0][CODE_BITS-1:0] codes,
    output logic                             cmd_valid,
    input  logic                             cmd_ready,
    output logic [ADDR_W-1:0]                cmd_addr,
    output logic [CODE_BITS-1:0]             cmd_code,
    output logic [IDX_W-1:0]                 cmd_comp,
    output logic                             done
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  cidx_q;
    logic [CNT_W-1:0]  rem_q;
    logic              hs;
    logic              last;

    // Output decode from state
    always_comb begin
        calc_start = (state_q == SQ_IDLE) && start_col;
        q_start    = (state_q == SQ_ROW_WAIT) && smp_valid;
        smp_ready  = (state_q == SQ_ROW_WAIT);
        cmd_valid  = ((state_q == SQ_COL_ISSUE) && (rem_q != '0)) ||
                     (state_q == SQ_ROW_ISSUE);
        cmd_addr   = addr_q;
        cmd_comp   = cidx_q;
        cmd_code   = codes[cidx_q];
        hs         = cmd_valid && cmd_ready;
        last       = (addr_q == ADDR_W'(N_CELLS - 1));
    end

    // Run control and address bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            cidx_q  <= '0;
            rem_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start_col) begin
                        state_q <= SQ_CALC;
                        addr_q  <= '0;
                        cidx_q  <= '0;
                    end else if (start_row) begin
                        state_q <= SQ_ROW_WAIT;
                        addr_q  <= '0;
                    end
                end
                SQ_CALC: if (calc_done) state_q <= SQ_COL_LOAD;
                SQ_COL_LOAD: begin
                    rem_q   <= counts[cidx_q];
                    state_q <= SQ_COL_ISSUE;
                end
                SQ_COL_ISSUE: begin
                    if (rem_q == '0) begin
                        if (cidx_q == IDX_W'(K_COMP - 1)) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            cidx_q  <= cidx_q + 1'b1;
                            state_q <= SQ_COL_LOAD;
                        end
                    end else if (hs) begin
                        rem_q <= rem_q - 1'b1;
                        if (last) begin
                            state_q <= SQ_IDLE;
                            done    <= 1'b1;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                end
                SQ_ROW_WAIT: if (smp_valid) state_q <= SQ_ROW_SEARCH;
                SQ_ROW_SEARCH: begin
                    if (q_done) begin
                        cidx_q  <= q_idx;
                        state_q <= SQ_ROW_ISSUE;
                    end
                end
                SQ_ROW_ISSUE: begin
                    if (hs) begin
                        if (last) begin
                            state_q <= SQ_IDLE;
                            done    <= 1'b1;
                        end else begin
                            addr_q  <= addr_q + 1'b1;
                            state_q <= SQ_ROW_WAIT;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_comp)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !last) |=> (cmd_addr == ADDR_W'($past(cmd_addr) + 1'b1)));

endmodule

// File: rtl/mix_alloc_sched.sv
// Top of the mixture allocation scheduler: configuration store, count
// calculator, nearest-median search and command sequencer.
// Assumes N_CELLS is at least 2 and K_COMP at least 2.
module mix_alloc_sched #(
    parameter int N_CELLS   = 1024,
    parameter int K_COMP    = 5,
    parameter int W_BITS    = 16,
    parameter int CODE_BITS = 8,
    parameter int MED_LO    = 40,
    parameter int MED_HI    = 240,
    parameter int IDX_W     = $clog2(K_COMP),
    parameter int ADDR_W    = $clog2(N_CELLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_field,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [W_BITS-1:0]    cfg_wdata,
    output logic                 cfg_reject,
    input  logic                 start_col,
    input  logic                 start_row,
    input  logic                 smp_valid,
    output logic                 smp_ready,
    input  logic [CODE_BITS-1:0] smp_value,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [CODE_BITS-1:0] cmd_code,
    output logic [IDX_W-1:0]     cmd_comp,
    output logic                 done
);

    localparam int CNT_W = $clog2(N_CELLS + 1);

    logic [K_COMP-1:0][W_BITS-1:0]    weights;
    logic [K_COMP-1:0][CODE_BITS-1:0] medians;
    logic [K_COMP-1:0][CODE_BITS-1:0] codes;
    logic [K_COMP-1:0][CNT_W-1:0]     counts;
    logic                             calc_start;
    logic                             calc_done;
    logic                             q_start;
    logic                             q_done;
    logic [IDX_W-1:0]                 q_idx;

    mix_cfg_regs #(
        .K_COMP(K_COMP), .W_BITS(W_BITS), .CODE_BITS(CODE_BITS),
        .MED_LO(MED_LO), .MED_HI(MED_HI), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_reject(cfg_reject),
        .weights(weights), .medians(medians), .codes(codes)
    );

    mix_count_calc #(
        .N_CELLS(N_CELLS), .K_COMP(K_COMP), .W_BITS(W_BITS),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_calc (
        .clk(clk), .rst_n(rst_n), .start(calc_start), .weights(weights),
        .counts(counts), .done(calc_done)
    );

    mix_nearest_search #(
        .K_COMP(K_COMP), .CODE_BITS(CODE_BITS), .IDX_W(IDX_W)
    ) u_search (
        .clk(clk), .rst_n(rst_n), .start(q_start), .value(smp_value),
        .medians(medians), .done(q_done), .idx(q_idx)
    );

    mix_issue_seq #(
        .N_CELLS(N_CELLS), .K_COMP(K_COMP), .CODE_BITS(CODE_BITS),
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_col(start_col), .start_row(start_row),
        .calc_start(calc_start), .calc_done(calc_done), .counts(counts),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .q_start(q_start),
        .q_done(q_done), .q_idx(q_idx), .codes(codes),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_code(cmd_code), .cmd_comp(cmd_comp), .done(done)
    );

endmodule

// File: tb/test_mix_alloc_sched.sv
// Self-checking bench: directed corner cases plus seeded random weights,
// samples and ready throttling, compared against bench-side models.
module test_mix_alloc_sched;

    localparam int N  = 1024;
    localparam int K  = 5;
    localparam int IW = 3;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_field = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          cfg_reject;
    logic          start_col = 1'b0;
    logic          start_row = 1'b0;
    logic          smp_valid = 1'b0;
    logic          smp_ready;
    logic [7:0]    smp_value = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_code;
    logic [IW-1:0] cmd_comp;
    logic          done;

    mix_alloc_sched i_mix_alloc_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_reject(cfg_reject),
        .start_col(start_col), .start_row(start_row), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_value(smp_value), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_code(cmd_code),
        .cmd_comp(cmd_comp), .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int w_m[K];
    int med_m[K];
    int code_m[K];
    int ec[K];
    int obs[K];
    int exp_comp[N];
    int smp_v[N];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R1 R2 model: rounded shares, limited to free cells, last takes rest
    task automatic calc_counts();
        int acc = 0;
        for (int k = 0; k < K; k++) begin
            int r = (N * w_m[k] + 32768) >>> 16;
            if (k == K - 1 || r > N - acc) r = N - acc;
            ec[k] = r;
            acc += r;
        end
    endtask

    // R4 model: first minimum distance wins
    function automatic int nearest(input int v);
        int best = 0;
        int bd = 1000;
        for (int k = 0; k < K; k++) begin
            int d = (v >= med_m[k]) ? v - med_m[k] : med_m[k] - v;
            if (d < bd) begin
                bd = d;
                best = k;
            end
        end
        return best;
    endfunction

    task automatic wr(input int fld, input int idx, input int data);
        bit bad = (fld == 1) && (data < 40 || data > 240);
        @(negedge clk);
        cfg_we = 1'b1; cfg_field = 2'(fld); cfg_idx = IW'(idx); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (fld == 1) chk(cfg_reject == bad, "R6 reject flag", int'(cfg_reject), int'(bad));
        if (!bad) begin
            if (fld == 0) w_m[idx] = data;
            if (fld == 1) med_m[idx] = data;
            if (fld == 2) code_m[idx] = data;
        end
    endtask

    // Take commands with random ready until done; check each one
    task automatic consume(input bit rowmode);
        int got = 0;
        int cyc = 0;
        bit pend = 1'b0;
        int p_addr = 0, p_code = 0, p_comp = 0;
        for (int k = 0; k < K; k++) obs[k] = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (pend)
                chk(cmd_valid && int'(cmd_addr) == p_addr && int'(cmd_code) == p_code
                    && int'(cmd_comp) == p_comp, "R7 held payload", int'(cmd_addr), p_addr);
            if (done) break;
            if (cyc > 20 * N + 1000) begin
                chk(1'b0, "R8 run never ended", got, N);
                break;
            end
            if (cmd_valid) begin
                bit r = ($urandom_range(0, 3) != 0);
                cmd_ready = r;
                if (r) begin
                    int e = (got < N) ? exp_comp[got] : 0;
                    chk(int'(cmd_addr) == got, rowmode ? "R5 address" : "R3 address",
                        int'(cmd_addr), got);
                    chk(int'(cmd_comp) == e, rowmode ? "R4 component" : "R3 component",
                        int'(cmd_comp), e);
                    chk(int'(cmd_code) == code_m[e], rowmode ? "R4 code" : "R3 code",
                        int'(cmd_code), code_m[e]);
                    if (int'(cmd_comp) < K) obs[cmd_comp]++;
                    got++;
                    pend = 1'b0;
                end else begin
                    pend = 1'b1;
                    p_addr = int'(cmd_addr); p_code = int'(cmd_code); p_comp = int'(cmd_comp);
                end
            end else begin
                cmd_ready = 1'($urandom_range(0, 1));
                pend = 1'b0;
            end
        end
        chk(got == N, "R8 commands before done", got, N);
        chk(!cmd_valid, "R8 no command with done", int'(cmd_valid), 0);
        @(negedge clk);
        chk(!done && !cmd_valid, "R8 done one cycle", int'(done), 0);
        cmd_ready = 1'b0;
    endtask

    task automatic run_col();
        int p = 0;
        calc_counts();
        for (int k = 0; k < K; k++)
            for (int j = 0; j < ec[k]; j++) begin
                exp_comp[p] = k;
                p++;
            end
        @(negedge clk); start_col = 1'b1;
        @(negedge clk); start_col = 1'b0;
        consume(1'b0);
        for (int k = 0; k < K; k++)
            chk(obs[k] == ec[k], (k == K - 1) ? "R2 last count" : "R1 count", obs[k], ec[k]);
    endtask

    task automatic feed();
        for (int i = 0; i < N; i++) begin
            smp_valid = 1'b1;
            smp_value = 8'(smp_v[i]);
            if (i == 10) start_col = 1'b1;   // R10: must be ignored
            while (!smp_ready) begin
                @(negedge clk);
                start_col = 1'b0;
            end
            @(negedge clk);
            start_col = 1'b0;
        end
        smp_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5A17));
        for (int k = 0; k < K; k++) begin
            w_m[k] = 0; med_m[k] = 40; code_m[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R9
        chk(!cmd_valid && !done && !smp_ready && !cfg_reject, "R9 reset outputs",
            int'(cmd_valid) + int'(done) + int'(smp_ready) + int'(cfg_reject), 0);
        rst_n = 1'b1;

        for (int k = 0; k < K; k++) wr(2, k, 11 * (k + 1));
        // R1 reference split 85/333/107/177/322
        wr(0, 0, 5440); wr(0, 1, 21312); wr(0, 2, 6848); wr(0, 3, 11328); wr(0, 4, 20608);
        run_col();
        chk(obs[0] == 85 && obs[1] == 333 && obs[2] == 107 && obs[3] == 177,
            "R1 reference", obs[1], 333);
        chk(obs[4] == 322, "R2 reference last", obs[4], 322);

        // R1 random weights, often oversubscribed
        for (int k = 0; k < K; k++) wr(0, k, int'($urandom_range(0, 30000)));
        run_col();
        // R1 single full-scale weight
        for (int k = 0; k < K; k++) wr(0, k, (k == 1) ? 65535 : 0);
        run_col();
        // R2 all weights zero
        for (int k = 0; k < K; k++) wr(0, k, 0);
        run_col();
        // R1 two halves starve the rest
        for (int k = 0; k < K; k++) wr(0, k, (k < 2) ? 32768 : 0);
        run_col();

        // R6 medians: bounds accepted, out-of-range refused
        wr(1, 0, 40); wr(1, 1, 80); wr(1, 2, 120); wr(1, 3, 160); wr(1, 4, 240);
        wr(1, 2, 30); wr(1, 2, 241); wr(1, 2, 16'h0178);

        for (int i = 0; i < N; i++) smp_v[i] = int'($urandom_range(0, 255));
        smp_v[0] = 100; smp_v[1] = 0; smp_v[2] = 255; smp_v[3] = 60;
        smp_v[4] = 120; smp_v[5] = 200; smp_v[6] = 121;
        for (int i = 0; i < N; i++) exp_comp[i] = nearest(smp_v[i]);
        // R4 tie at 100 resolves to the lower index
        chk(exp_comp[0] == 1 && exp_comp[5] == 3, "R4 tie model", exp_comp[0], 1);
        // R6 the refused writes must leave median 120 on component 2
        chk(exp_comp[4] == 2, "R6 stored median", exp_comp[4], 2);
        @(negedge clk); start_row = 1'b1;
        @(negedge clk); start_row = 1'b0;
        fork
            feed();
            consume(1'b1);
        join
        // R10 the start request during the row run left it unchanged
        chk(obs[2] > 0 && !cmd_valid, "R10", obs[2], 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R8 actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule